// File: doc/BRIEF.md
# NAND Tree Connectivity Test Controller

This block gives test equipment a way to check board-level solder connectivity. It reads a strap pin once at power-up. If the strap is high, the block enters a test mode. In that mode a set of included input pins feeds a chain of two-input NAND stages, and the result drives a shared observation pin. The equipment first drives every included pin high and sees the observation pin go high. It then pulls the pins low one after another in a fixed order and watches the observation pin flip at each step.

The first serial bus transaction to the device ends test mode, and no later stimulus can bring it back. Only a new power-on reset lets the strap be read again. Outside test mode, and during the one cycle before the strap is read, the shared pin carries its normal function value. The tree path has no register, so the observation pin follows the included pins within the same cycle.

Top module: `ntree_ctrl`

## Requirements
- R1: While `rst` is high, `test_mode_o` and `tout_sel_o` are 0 and `tout_o` equals `normal_out_i`.
- R2: If `strap_i` is 1 and `bus_access_i` is 0 at the first rising edge with `rst` low, `test_mode_o` and `tout_sel_o` are 1 from that edge onward.
- R3: If `strap_i` is 0 at that first edge, the block enters functional mode. Raising `strap_i` later does not enter test mode.
- R4: After the first edge, `strap_i` is never sampled again, so lowering it while in test mode has no effect.
- R5: A 1 on `bus_access_i` at a rising edge during test mode ends test mode at that edge, and `tout_o` returns to `normal_out_i`.
- R6: Once test mode has ended, neither strap levels nor further bus accesses re-enter it. A new reset with the strap high does re-enter it.
- R7: In test mode, with every included pin at 1, `tout_o` is 1.
- R8: Bit 0 of `pins_i` is the serial data pin and is walked first. The top bit is the reset pin and is walked last. In test mode, when bits 0..k are low and the rest are high, `tout_o` is 1 exactly when k+1 is even, so each step of the walk toggles the output.
- R9: In functional mode `tout_sel_o` is 0 and `tout_o` equals `normal_out_i` whatever `pins_i` holds.
- R10: A bus access in the same edge that reads a high strap wins, and the block enters functional mode.
- R11: In test mode a change on `pins_i` reaches `tout_o` in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| strap_i | input | 1 | Test-entry strap level |
| bus_access_i | input | 1 | Strobe, one cycle per detected serial bus access |
| pins_i | input | N_PINS | Included pin levels; bit 0 is walked first |
| normal_out_i | input | 1 | Value of the shared pin's normal function |
| tout_o | output | 1 | Drive value for the shared observation pin |
| tout_sel_o | output | 1 | 1 when the tree result is selected |
| test_mode_o | output | 1 | Test mode active |

## Verification
Two events can meet at the same edge: the one-time strap read and the first bus access. The bench releases reset with the strap high and the access strobe asserted in that same cycle. It then expects functional mode on the following cycle, with `tout_o` tracking `normal_out_i`. A second collision drives a pin pattern change in the same cycle as the exiting access. That cycle must still show the tree value, and the next cycle must show the normal value.

// File: rtl/ntree_pkg.sv
package ntree_pkg;

    // Default number of pins included in the tree
    localparam int TREE_PINS_DEF = 16;

    typedef enum logic [1:0] {
        MD_ARM  = 2'd0,   // reset released, strap not yet read
        MD_TEST = 2'd1,   // tree drives the shared pin
        MD_FUNC = 2'd2    // normal function, final until reset
    } mode_e;

    typedef struct packed {
        logic sel;
        logic value;
    } pin_drive_t;

    // A chain of NAND stages seeded with 1 ends at 1 for an even count when all
    // inputs are high; an odd count needs a final inversion.
    function automatic logic chain_needs_invert(input int n);
        return (n % 2) == 1;
    endfunction

    function automatic mode_e mode_after_strap(input logic strap, input logic access);
        return (strap && !access) ? MD_TEST : MD_FUNC;
    endfunction

endpackage

// File: rtl/ntree_mode_fsm.sv
module ntree_mode_fsm
    import ntree_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  strap_i,
    input  logic  bus_access_i,
    output mode_e mode_o
);

    mode_e mode_q;
    mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MD_ARM:  mode_d = mode_after_strap(strap_i, bus_access_i);
            MD_TEST: if (bus_access_i) mode_d = MD_FUNC;
            MD_FUNC: mode_d = MD_FUNC;
            default: mode_d = MD_FUNC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MD_ARM;
        else     mode_q <= mode_d;
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/ntree_chain.sv
module ntree_chain
    import ntree_pkg::*;
#(
    parameter int N_PINS = TREE_PINS_DEF
) (
    input  logic [N_PINS-1:0] pins_i,
    output logic              tree_o
);

    localparam bit INVERT = chain_needs_invert(N_PINS);

    logic [N_PINS-1:0] stage;

    assign stage[0] = ~pins_i[0];

    for (genvar g = 1; g < N_PINS; g++) begin : g_stage
        assign stage[g] = ~(stage[g-1] & pins_i[g]);
    end

    if (INVERT) begin : g_inv
        assign tree_o = ~stage[N_PINS-1];
    end else begin : g_direct
        assign tree_o = stage[N_PINS-1];
    end

endmodule

// File: rtl/ntree_outmux.sv
module ntree_outmux
    import ntree_pkg::*;
(
    input  mode_e      mode_i,
    input  logic       tree_i,
    input  logic       normal_i,
    output pin_drive_t drive_o
);

    always_comb begin
        drive_o.sel   = (mode_i == MD_TEST);
        drive_o.value = drive_o.sel ? tree_i : normal_i;
    end

endmodule

// File: rtl/ntree_ctrl.sv
module ntree_ctrl
    import ntree_pkg::*;
#(
    parameter int N_PINS = TREE_PINS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_i,
    input  logic              bus_access_i,
    input  logic [N_PINS-1:0] pins_i,
    input  logic              normal_out_i,
    output logic              tout_o,
    output logic              tout_sel_o,
    output logic              test_mode_o
);

    mode_e      mode;
    logic       tree;
    pin_drive_t drive;

    ntree_mode_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .strap_i      (strap_i),
        .bus_access_i (bus_access_i),
        .mode_o       (mode)
    );

    ntree_chain #(.N_PINS(N_PINS)) u_chain (
        .pins_i (pins_i),
        .tree_o (tree)
    );

    ntree_outmux u_mux (
        .mode_i   (mode),
        .tree_i   (tree),
        .normal_i (normal_out_i),
        .drive_o  (drive)
    );

    assign tout_o      = drive.value;
    assign tout_sel_o  = drive.sel;
    assign test_mode_o = (mode == MD_TEST);

endmodule

// File: rtl/ntree_ctrl_chk.sv
module ntree_ctrl_chk #(
    parameter int N_PINS = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              strap_i,
    input logic              bus_access_i,
    input logic [N_PINS-1:0] pins_i,
    input logic              normal_out_i,
    input logic              tout_o,
    input logic              tout_sel_o,
    input logic              test_mode_o
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!test_mode_o && !tout_sel_o));

    a_r2_strap_enters: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && strap_i && !bus_access_i) |=> test_mode_o);

    a_r4_holds_test: assert property (@(posedge clk) disable iff (rst)
        (test_mode_o && !bus_access_i) |=> test_mode_o);

    a_r5_access_exits: assert property (@(posedge clk) disable iff (rst)
        (test_mode_o && bus_access_i) |=> !test_mode_o);

    a_r6_no_reentry: assert property (@(posedge clk) disable iff (rst)
        (!test_mode_o && !$past(rst)) |=> !test_mode_o);

    a_r10_access_wins: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && bus_access_i) |=> !test_mode_o);

    a_r7_all_high: assert property (@(posedge clk) disable iff (rst)
        (test_mode_o && (&pins_i)) |-> tout_o);

    a_r9_sel_matches_mode: assert property (@(posedge clk) disable iff (rst)
        tout_sel_o == test_mode_o);

endmodule

bind ntree_ctrl ntree_ctrl_chk #(.N_PINS(N_PINS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .strap_i      (strap_i),
    .bus_access_i (bus_access_i),
    .pins_i       (pins_i),
    .normal_out_i (normal_out_i),
    .tout_o       (tout_o),
    .tout_sel_o   (tout_sel_o),
    .test_mode_o  (test_mode_o)
);

// File: tb/ntree_ctrl_bench.sv
module ntree_ctrl_bench;

    localparam int CLK_P = 10;
    localparam int N = 16;

    typedef struct {
        logic  tm;
        logic  out;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         strap = 1'b0;
    logic         acc = 1'b0;
    logic [N-1:0] pins = '1;
    logic         nrm = 1'b0;
    logic         tout, tsel, tmode;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ntree_ctrl #(.N_PINS(N)) u_ntree_ctrl (
        .clk          (clk),
        .rst          (rst),
        .strap_i      (strap),
        .bus_access_i (acc),
        .pins_i       (pins),
        .normal_out_i (nrm),
        .tout_o       (tout),
        .tout_sel_o   (tsel),
        .test_mode_o  (tmode)
    );

    // Drive at a falling edge; the expected item describes the outputs during
    // this same cycle (state from the previous rising edge).
    task automatic step(input logic r, input logic st, input logic ac,
                        input logic [N-1:0] p, input logic nv,
                        input logic etm, input logic eout, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; strap = st; acc = ac; pins = p; nrm = nv;
        e.tm = etm; e.out = eout; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (tmode !== e.tm || tsel !== e.tm || tout !== e.out) begin
                    n_fail++;
                    $display("FAIL %s: mode=%b sel=%b out=%b expected mode=%b sel=%b out=%b",
                             e.tag, tmode, tsel, tout, e.tm, e.tm, e.out);
                end
            end
        end
    end

    initial begin
        #(CLK_P*5000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] m;
        // Power-on reset
        @(negedge clk); @(negedge clk);
        step(1, 1, 0, '1, 0, 0, 0, "R1");
        step(1, 1, 0, '0, 1, 0, 1, "R1");
        // Release with strap high: arm cycle shows the normal value
        step(0, 1, 0, '1, 0, 0, 0, "R2");
        step(0, 0, 0, '1, 0, 1, 1, "R2_R7");
        step(0, 0, 0, '1, 1, 1, 1, "R4");
        // Walk: bits 0..k low
        for (int k = 0; k < N; k++) begin
            m = '1 << (k + 1);
            step(0, k[0], 0, m, k[1], 1, ((k + 1) % 2) == 0, "R8");
        end
        step(0, 1, 0, '1, 0, 1, 1, "R7");
        // Same-cycle response of the tree
        step(0, 0, 0, {{(N-1){1'b1}}, 1'b0}, 1, 1, 0, "R11");
        step(0, 0, 0, '1, 0, 1, 1, "R11");
        // Bus access ends test mode; its own cycle still shows the tree
        step(0, 0, 1, {{(N-1){1'b1}}, 1'b0}, 1, 1, 0, "R5");
        step(0, 0, 0, '0, 0, 0, 0, "R5");
        step(0, 0, 0, '0, 1, 0, 1, "R9");
        step(0, 0, 0, '1, 0, 0, 0, "R9");
        // No re-entry by strap or more accesses
        step(0, 1, 1, '1, 1, 0, 1, "R6");
        step(0, 1, 0, '1, 0, 0, 0, "R6");
        step(0, 1, 0, '1, 1, 0, 1, "R6");
        // Power cycle with strap low
        step(1, 0, 0, '1, 0, 0, 0, "R1");
        step(0, 0, 0, '1, 1, 0, 1, "R3");
        step(0, 1, 0, '1, 0, 0, 0, "R3");
        step(0, 1, 0, '0, 1, 0, 1, "R3");
        // Collision: access at the strap-read edge
        step(1, 1, 0, '1, 0, 0, 0, "R1");
        step(0, 1, 1, '1, 1, 0, 1, "R10");
        step(0, 1, 0, '1, 0, 0, 0, "R10");
        // Re-entry after a new reset
        step(1, 1, 0, '1, 1, 0, 1, "R1");
        step(0, 1, 0, '1, 0, 0, 0, "R6");
        step(0, 1, 0, '1, 0, 1, 1, "R6");
        step(0, 0, 0, {{(N-1){1'b1}}, 1'b0}, 0, 1, 0, "R8");
        // Drain
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule